// File: doc/BRIEF.md
# Serial Slave Port with Shared Data-Ready Line

This block is the serial face of a converter-style peripheral. A fast system clock samples the bus pins, and it runs one SPI transfer at a time. An internal producer hands in 16-bit results through a one-cycle valid strobe. While the port is selected and no transfer is running, the single output line reports whether an unread result is waiting. During a transfer that same line carries the result out, most significant bit first, while the incoming bits form a 16-bit configuration word.

A transfer takes a snapshot of the result when it starts, so a producer update during the transfer is held back until the transfer is over. Transfers that stop part way are cleared in one of two ways: by deselecting the port, or by leaving the serial clock low longer than a cycle-count timeout. The timeout is the only recovery when chip select is tied low. In continuous mode an unread result stops being announced a set number of cycles before the next result is due. A configuration bit decides whether the output line is weakly pulled up or left floating while the port is deselected.

Top module: `spi_ready_slave`

## Requirements
- R1: While the synchronized chip select is high, the output enable is low and any partial transfer is discarded. Clock edges are ignored, and the ready state and the held result are kept.
- R2: While selected and not transferring, the data line is 0 when an unread result is present and 1 when none is.
- R3: A transfer is 16 serial-clock cycles. The input bit is captured on each falling edge, and the word is assembled most significant bit first. The output bit changes on each rising edge, starting with the result's bit 15. At the 16th falling edge the received word becomes the configuration word.
- R4: The result is copied for shifting at the first rising edge of a transfer and does not change until the transfer ends. A result that arrives during a transfer becomes the readable result once the transfer ends, and it sets the ready state.
- R5: A completed 16-bit transfer clears the ready state unless a result was held back during it.
- R6: If the serial clock stays low for TIMEOUT_CYC system cycles during a transfer, the transfer is discarded and the next rising edge starts a new one. This applies with chip select held low.
- R7: When configuration bit 1 is 1 (continuous mode), an unread result stops being announced, and the line returns to 1, PERIOD_CYC minus LEAD_CYC cycles after that result was accepted. When bit 1 is 0, the announcement stays until the result is read.
- R8: When configuration bit 0 is 1, the pull-up enable is high while deselected. When bit 0 is 0, both the pull-up enable and the output enable are low while deselected. The pull-up enable is always low while selected.
- R9: After reset the ready state is clear, the configuration word is 16'h0001, and a transfer made before any result arrives reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, idles low |
| csn_i | input | 1 | Active-low chip select |
| mosi_i | input | 1 | Serial data into the block |
| res_valid_i | input | 1 | One-cycle strobe marking a new result |
| res_data_i | input | 16 | New result from the producer |
| miso_o | output | 1 | Serial data out, or ready status when idle |
| miso_oe_o | output | 1 | Output enable for the data line |
| miso_pu_o | output | 1 | Weak pull-up enable for the data line |
| cfg_o | output | 16 | Configuration word received in the last complete transfer |

## Verification
The hardest case to reach from the ports is a producer result that arrives in the middle of a transfer. The bench raises the valid strobe during the low phase of a chosen serial bit inside its transfer task. It then checks that the word being shifted out is still the old one, that the line signals ready right after the frame, and that a second transfer returns the new value. The timeout case is reached by stopping after six bits with chip select held low and waiting past the limit. The following full transfer must read and write correctly aligned words.

// File: rtl/spi_rdy_pkg.sv
package spi_rdy_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned CFG_PU_BIT = 0;
  localparam int unsigned CFG_CONT_BIT = 1;
  localparam logic [WORD_W-1:0] CFG_RESET = 16'h0001;

  // cycle, counted from result acceptance, at which the ready flag is withdrawn
  function automatic int unsigned withdraw_point(int unsigned period, int unsigned lead);
    return (period > lead) ? period - lead : 0;
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned N = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] s1_q, s2_q;
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q[i] <= RST_VAL[i];
        s2_q[i] <= RST_VAL[i];
      end else begin
        s1_q[i] <= d_i[i];
        s2_q[i] <= s1_q[i];
      end
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/spi_frame.sv
module spi_frame #(
  parameter int unsigned W = 16,
  parameter int unsigned TIMEOUT_CYC = 200
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_act,
  input  logic         sclk_s,
  input  logic         mosi_s,
  input  logic [W-1:0] result,
  output logic         busy,
  output logic         tx_bit,
  output logic [W-1:0] rx_word,
  output logic         frame_done,
  output logic         frame_abort
);
  localparam int unsigned CW = $clog2(W + 1);
  localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);

  logic          sclk_d, busy_q;
  logic [CW-1:0] bitcnt_q;
  logic [TW-1:0] idle_q;
  logic [W-1:0]  tx_sh_q, rx_sh_q;

  // named events for the assertions and the tracker
  logic sclk_rise, sclk_fall, start, timeout_hit;
  assign sclk_rise   = sclk_s & ~sclk_d;
  assign sclk_fall   = ~sclk_s & sclk_d;
  assign start       = cs_act & sclk_rise & ~busy_q;
  assign timeout_hit = busy_q & (idle_q == TW'(TIMEOUT_CYC));
  assign frame_abort = busy_q & (~cs_act | timeout_hit);
  assign frame_done  = busy_q & cs_act & ~timeout_hit & sclk_fall
                       & (bitcnt_q == CW'(W - 1));
  assign rx_word     = {rx_sh_q[W-2:0], mosi_s};
  assign busy        = busy_q;
  assign tx_bit      = tx_sh_q[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      busy_q   <= 1'b0;
      bitcnt_q <= '0;
      idle_q   <= '0;
      tx_sh_q  <= '0;
      rx_sh_q  <= '0;
    end else begin
      sclk_d <= sclk_s;
      if (busy_q && !sclk_s && idle_q < TW'(TIMEOUT_CYC)) idle_q <= idle_q + 1'b1;
      else if (!busy_q || sclk_s)                         idle_q <= '0;

      if (frame_abort) begin
        busy_q   <= 1'b0;
        bitcnt_q <= '0;
      end else if (start) begin
        busy_q  <= 1'b1;
        tx_sh_q <= result;
      end else if (busy_q) begin
        if (sclk_rise) tx_sh_q <= tx_sh_q << 1;
        if (sclk_fall) begin
          rx_sh_q <= rx_word;
          if (frame_done) begin
            busy_q   <= 1'b0;
            bitcnt_q <= '0;
          end else begin
            bitcnt_q <= bitcnt_q + 1'b1;
          end
        end
      end
    end
  end

  assert_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (!busy_q && bitcnt_q == '0));
  assert_bitcount_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt_q < CW'(W));
  assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !sclk_rise) |=> $stable(tx_sh_q));
  assert_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_hit |=> !busy_q);
endmodule

// File: rtl/spi_ready_track.sv
module spi_ready_track
  import spi_rdy_pkg::*;
#(
  parameter int unsigned W = 16,
  parameter int unsigned PERIOD_CYC = 300,
  parameter int unsigned LEAD_CYC = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         busy,
  input  logic         frame_done,
  input  logic         frame_abort,
  input  logic         res_valid,
  input  logic [W-1:0] res_data,
  input  logic         cont_en,
  output logic         ready,
  output logic [W-1:0] result
);
  localparam int unsigned PW    = $clog2(PERIOD_CYC + 1);
  localparam int unsigned WD_AT = withdraw_point(PERIOD_CYC, LEAD_CYC);

  logic          ready_q, pend_v_q;
  logic [W-1:0]  result_q, pend_q;
  logic [PW-1:0] timer_q;

  logic frame_end, promote, direct, wd_fire;
  assign frame_end = frame_done | frame_abort;
  assign promote   = frame_end & (res_valid | pend_v_q);
  assign direct    = ~frame_end & ~busy & res_valid;
  assign wd_fire   = cont_en & ready_q & ~busy & ~frame_end & ~direct
                     & (timer_q >= PW'(WD_AT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q  <= 1'b0;
      pend_v_q <= 1'b0;
      result_q <= '0;
      pend_q   <= '0;
      timer_q  <= '0;
    end else begin
      if (timer_q < PW'(PERIOD_CYC)) timer_q <= timer_q + 1'b1;
      if (frame_end) begin
        pend_v_q <= 1'b0;
        if (promote) begin
          result_q <= res_valid ? res_data : pend_q;
          ready_q  <= 1'b1;
          timer_q  <= '0;
        end else if (frame_done) begin
          ready_q <= 1'b0;
        end
      end else if (direct) begin
        result_q <= res_data;
        ready_q  <= 1'b1;
        timer_q  <= '0;
      end else if (res_valid) begin
        pend_q   <= res_data;
        pend_v_q <= 1'b1;
      end else if (wd_fire) begin
        ready_q <= 1'b0;
      end
    end
  end

  assign ready  = ready_q;
  assign result = result_q;

  assert_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    promote |=> ready_q);
  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !promote) |=> !ready_q);
  assert_withdraw_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fire |=> !ready_q);
  assert_no_withdraw_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cont_en && ready_q && !frame_end) |=> ready_q);
endmodule

// File: rtl/spi_ready_slave.sv
module spi_ready_slave
  import spi_rdy_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 200,
  parameter int unsigned PERIOD_CYC = 300,
  parameter int unsigned LEAD_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              mosi_i,
  input  logic              res_valid_i,
  input  logic [WORD_W-1:0] res_data_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic              miso_pu_o,
  output logic [WORD_W-1:0] cfg_o
);
  logic [2:0]        pins_s;
  logic              sclk_s, csn_s, mosi_s, cs_act;
  logic              busy, tx_bit, frame_done, frame_abort, ready;
  logic [WORD_W-1:0] rx_word, result, cfg_q;

  spi_sync #(.N(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({mosi_i, csn_i, sclk_i}), .q_o(pins_s));
  assign {mosi_s, csn_s, sclk_s} = pins_s;
  assign cs_act = ~csn_s;

  spi_frame #(.W(WORD_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_s(sclk_s), .mosi_s(mosi_s),
    .result(result), .busy(busy), .tx_bit(tx_bit), .rx_word(rx_word),
    .frame_done(frame_done), .frame_abort(frame_abort));

  spi_ready_track #(.W(WORD_W), .PERIOD_CYC(PERIOD_CYC), .LEAD_CYC(LEAD_CYC)) u_track (
    .clk(clk), .rst_n(rst_n), .busy(busy), .frame_done(frame_done),
    .frame_abort(frame_abort), .res_valid(res_valid_i), .res_data(res_data_i),
    .cont_en(cfg_q[CFG_CONT_BIT]), .ready(ready), .result(result));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cfg_q <= CFG_RESET;
    else if (frame_done) cfg_q <= rx_word;
  end

  assign cfg_o     = cfg_q;
  assign miso_oe_o = cs_act;
  assign miso_pu_o = ~cs_act & cfg_q[CFG_PU_BIT];
  assign miso_o    = !cs_act ? 1'b1 : (busy ? tx_bit : ~ready);

  assert_pullup_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(miso_pu_o && miso_oe_o));
  assert_cfg_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(cfg_q));
endmodule

// File: tb/tb_spi_ready_slave.sv
module tb_spi_ready_slave;
  localparam int CLK_PERIOD = 10;
  localparam int TIMEOUT = 200;
  localparam int PERIOD = 300;
  localparam int LEAD = 40;
  localparam int WD_AT = PERIOD - LEAD;

  logic clk = 0, rst_n = 0, sclk = 0, csn = 1, mosi = 0, rv = 0;
  logic [15:0] rd = '0;
  logic miso, oe, pu;
  logic [15:0] cfg;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_ready_slave #(.TIMEOUT_CYC(TIMEOUT), .PERIOD_CYC(PERIOD), .LEAD_CYC(LEAD)) dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .mosi_i(mosi),
    .res_valid_i(rv), .res_data_i(rd), .miso_o(miso), .miso_oe_o(oe),
    .miso_pu_o(pu), .cfg_o(cfg));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [15:0] v);
    @(negedge clk); rv = 1; rd = v;
    @(negedge clk); rv = 0;
  endtask

  task automatic select(input logic lo);
    @(negedge clk); csn = ~lo;
    wait_cyc(4);
  endtask

  // n serial bits; a producer result can be injected in the low phase of bit inj_at
  task automatic xfer(input logic [15:0] tx, input int n, input int inj_at,
                      input logic [15:0] inj_val, output logic [15:0] rx);
    rx = '0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk); mosi = tx[15-k]; sclk = 1;
      wait_cyc(4);
      rx[15-k] = miso;
      sclk = 0;
      if (k == inj_at) begin rv = 1; rd = inj_val; end
      @(negedge clk); rv = 0;
      wait_cyc(4);
    end
  endtask

  task automatic t_reset;
    logic [15:0] rx;
    check("R9 cfg reset", cfg, 16'h0001);
    check("R8 pull-up while deselected", {14'd0, oe, pu}, 16'h0001);
    select(1);
    check("R9/R2 no ready after reset", {15'd0, miso}, 16'h0001);
    xfer(16'h0001, 16, -1, '0, rx);
    check("R9 first read zero", rx, 16'h0000);
  endtask

  task automatic t_basic;
    logic [15:0] rx;
    push(16'hA5C3); wait_cyc(2);
    check("R2 ready shown low", {15'd0, miso}, 16'h0000);
    xfer(16'h8001, 16, -1, '0, rx);
    wait_cyc(2);
    check("R3 result shifted MSB first", rx, 16'hA5C3);
    check("R3 cfg written", cfg, 16'h8001);
    check("R5 ready cleared after read", {15'd0, miso}, 16'h0001);
  endtask

  task automatic t_freeze;
    logic [15:0] rx;
    push(16'h1111); wait_cyc(2);
    xfer(16'h0001, 16, 4, 16'h2222, rx);
    wait_cyc(2);
    check("R4 result frozen during frame", rx, 16'h1111);
    check("R4 pending result announced", {15'd0, miso}, 16'h0000);
    xfer(16'h0001, 16, -1, '0, rx);
    check("R4 pending result readable", rx, 16'h2222);
  endtask

  task automatic t_abort;
    logic [15:0] rx;
    push(16'hBEEF); wait_cyc(2);
    xfer(16'h0000, 5, -1, '0, rx);
    select(0);
    check("R1 output disabled when deselected", {15'd0, oe}, 16'h0000);
    wait_cyc(3);
    @(negedge clk); sclk = 1; wait_cyc(4); sclk = 0; wait_cyc(4);
    select(1);
    check("R1 ready kept over abort", {15'd0, miso}, 16'h0000);
    xfer(16'h0001, 16, -1, '0, rx);
    wait_cyc(2);
    check("R1 fresh frame after deselect", rx, 16'hBEEF);
    check("R1 cfg aligned after deselect", cfg, 16'h0001);
  endtask

  task automatic t_hiz;
    logic [15:0] rx;
    xfer(16'h0000, 16, -1, '0, rx);
    select(0);
    check("R8 float mode no pull-up", {14'd0, oe, pu}, 16'h0000);
    select(1);
    check("R8 no pull-up while selected", {15'd0, pu}, 16'h0000);
    xfer(16'h0001, 16, -1, '0, rx);
    select(0);
    check("R8 pull-up restored", {15'd0, pu}, 16'h0001);
    select(1);
  endtask

  task automatic t_cont;
    logic [15:0] rx;
    push(16'h0F0F);
    wait_cyc(WD_AT + 20);
    check("R7 no withdraw when not continuous", {15'd0, miso}, 16'h0000);
    xfer(16'h0003, 16, -1, '0, rx);
    check("R7 read before withdraw test", rx, 16'h0F0F);
    push(16'h7777);
    wait_cyc(WD_AT - 5);
    check("R7 still ready before withdraw point", {15'd0, miso}, 16'h0000);
    wait_cyc(10);
    check("R7 ready withdrawn before next result", {15'd0, miso}, 16'h0001);
  endtask

  task automatic t_timeout;
    logic [15:0] rx;
    push(16'h3C3C); wait_cyc(2);
    xfer(16'hFFFF, 6, -1, '0, rx);
    wait_cyc(TIMEOUT + 10);
    xfer(16'h0001, 16, -1, '0, rx);
    wait_cyc(2);
    check("R6 frame realigned by timeout", rx, 16'h3C3C);
    check("R6 cfg realigned by timeout", cfg, 16'h0001);
  endtask

  initial begin
    wait_cyc(5);
    rst_n = 1;
    wait_cyc(4);
    t_reset;
    t_basic;
    t_freeze;
    t_abort;
    t_hiz;
    t_cont;
    t_timeout;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule